// File: doc/BRIEF.md
# Tile Buffer Back End with External Swap

This block is the pixel back end of a tiled rasterizer. It keeps exactly one screen tile resident on chip: a 32-bit color word per pixel and, when depth is in use, a 32-bit depth word per pixel. Incoming pixels are resolved against that resident copy in a single cycle. This covers the depth compare, the optional alpha blend and the write-back, so no pixel operation ever reaches external memory.

When a pixel lands outside the resident tile, the block stalls the pixel stream. If the resident tile was modified, it is written out through a burst master port. The target tile is then fetched back through the same port, and the stalled pixel is taken once the fetch is complete. Each transfer is cut into bursts of at most 4 KiB. Three free-running counters report the work done: one for tile loads, one for bytes read from external memory and one for bytes written to it.

Top module: `tile_store`

## Requirements
- R1: Pixel (x, y) belongs to tile t = (y / TILE_H) * (SCREEN_W / TILE_W) + x / TILE_W. Its word sits at byte offset ((y mod TILE_H) * TILE_W + x mod TILE_W) * 4 inside the tile. A tile plane starts at base + t * TILE_W * TILE_H * 4, where base is COLOR_BASE for color and DEPTH_BASE for depth. TILE_W and TILE_H are powers of two, for example 32x32 or 64x32.
- R2: With blending off, a pixel that is written stores its 32-bit source color unchanged, and a later write to the same pixel replaces it.
- R3: While depth is disabled for a resident tile, every pixel writes its color, and no depth word is read or written on chip or at the burst port.
- R4: While depth is enabled, a pixel passes when its depth is less than or equal to the stored depth (unsigned). A passing pixel updates both color and depth. A failing pixel changes neither.
- R5: With blending on, each of the four color bytes becomes (src*a + dst*(256-a)) >> 8, where a is source bits [31:24] and dst is the stored color.
- R6: A valid pixel that misses the resident tile starts a swap: an optional write-out, then a load of the target tile. reload_count increments by one at the start of each swap. The depth enable sampled at that moment governs the new tile until its next swap.
- R7: Every command requests BL = min(TILE_W*TILE_H, MAX_BURST_BYTES/4) beats of 4 bytes. A plane moves as ascending consecutive bursts. Within a swap the order is color write-out, depth write-out, color load, depth load, each present only when needed.
- R8: rd_bytes and wr_bytes count 4 bytes per accepted read beat and per accepted write beat respectively. Each counter advances independently of the other.
- R9: A tile is written out only if at least one pixel passed while it was resident. The first swap after reset only loads.
- R10: pix_ready is high only when no swap is in progress and the pixel hits the resident tile. The pixel is held stalled for the whole swap, and one hitting pixel is accepted per cycle.
- R11: After reset no tile is resident, all three counters are zero and no command or write beat is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| z_en | input | 1 | Depth enable, sampled when a swap starts |
| blend_en | input | 1 | Alpha blend enable for the current pixel |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel accepted this cycle |
| pix_x | input | $clog2(SCREEN_W) | Pixel column |
| pix_y | input | $clog2(SCREEN_H) | Pixel row |
| pix_z | input | 32 | Pixel depth |
| pix_color | input | 32 | Source color, alpha in bits [31:24] |
| cmd_valid | output | 1 | Burst command offered |
| cmd_ready | input | 1 | Burst command accepted |
| cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | output | ADDR_W | Burst start byte address |
| cmd_beats | output | $clog2(BL+1) | Beats in the burst |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Write beat accepted |
| wr_data | output | 32 | Write beat data |
| rd_valid | input | 1 | Read beat delivered |
| rd_data | input | 32 | Read beat data |
| reload_count | output | CNT_W | Tile loads since reset |
| rd_bytes | output | CNT_W | External bytes read |
| wr_bytes | output | CNT_W | External bytes written |

## Verification
The bench builds a 32x16 screen of 8x4 tiles with MAX_BURST_BYTES = 64. A swap then finishes in about a hundred cycles, so dozens of swaps fit into one run. Each plane is also split into two 16-beat bursts, which exercises burst splitting and address stepping that a 32x32 tile with 4 KiB bursts would cover in a single burst. The 16-tile screen is small enough that random traffic revisits tiles and flips depth mode between swaps. It also hits clean-tile skips and lets the final memory image be compared word by word.

// File: rtl/tile_store.sv
module tile_store #(
  parameter int SCREEN_W = 640,
  parameter int SCREEN_H = 480,
  parameter int TILE_W = 32,
  parameter int TILE_H = 32,
  parameter int MAX_BURST_BYTES = 4096,
  parameter int ADDR_W = 32,
  parameter int CNT_W = 32,
  parameter logic [ADDR_W-1:0] COLOR_BASE = '0,
  parameter logic [ADDR_W-1:0] DEPTH_BASE = ADDR_W'(32'h0100_0000),
  localparam int XW = $clog2(SCREEN_W),
  localparam int YW = $clog2(SCREEN_H),
  localparam int TILE_PIX = TILE_W * TILE_H,
  localparam int BL = (TILE_PIX < MAX_BURST_BYTES / 4) ? TILE_PIX : MAX_BURST_BYTES / 4,
  localparam int BW = $clog2(BL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              z_en,
  input  logic              blend_en,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [XW-1:0]     pix_x,
  input  logic [YW-1:0]     pix_y,
  input  logic [31:0]       pix_z,
  input  logic [31:0]       pix_color,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BW-1:0]     cmd_beats,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [31:0]       wr_data,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic [CNT_W-1:0]  reload_count,
  output logic [CNT_W-1:0]  rd_bytes,
  output logic [CNT_W-1:0]  wr_bytes
);
  localparam int LXW = $clog2(TILE_W);
  localparam int LYW = $clog2(TILE_H);
  localparam int IW = LXW + LYW;
  localparam int BLB = $clog2(BL);
  localparam int TILES_X = SCREEN_W / TILE_W;
  localparam int NT = TILES_X * (SCREEN_H / TILE_H);
  localparam int TW = $clog2(NT);
  localparam int TILE_BYTES = TILE_PIX * 4;

  typedef enum logic [2:0] {S_IDLE, S_WCMD, S_WDAT, S_RCMD, S_RDAT} st_t;
  st_t st;

  logic [31:0] cram [TILE_PIX];
  logic [31:0] zram [TILE_PIX];
  logic resident, dirty, zon, zload, plane;
  logic [TW-1:0] cur_tile, new_tile, tgt;
  logic [IW-1:0] idx, pidx;
  logic [31:0] dst, blended, newc;
  logic hit, acc, zpass, wr_fire, rd_fire, burst_end, plane_end, miss;

  assign tgt  = TW'(32'(pix_y[YW-1:LYW]) * TILES_X + 32'(pix_x[XW-1:LXW]));
  assign pidx = {pix_y[LYW-1:0], pix_x[LXW-1:0]};
  assign hit  = resident && tgt == cur_tile;
  assign miss = st == S_IDLE && pix_valid && !hit;
  assign pix_ready = st == S_IDLE && hit;
  assign acc   = pix_valid && pix_ready;
  assign dst   = cram[pidx];
  assign zpass = !zon || pix_z <= zram[pidx];

  for (genvar b = 0; b < 4; b++) begin : g_ch
    logic [16:0] mix;
    assign mix = 17'(pix_color[8*b +: 8]) * 17'(pix_color[31:24])
               + 17'(dst[8*b +: 8]) * (17'd256 - 17'(pix_color[31:24]));
    assign blended[8*b +: 8] = mix[15:8];
  end
  assign newc = blend_en ? blended : pix_color;

  assign cmd_valid = st == S_WCMD || st == S_RCMD;
  assign cmd_write = st == S_WCMD;
  assign cmd_beats = BW'(BL);
  assign cmd_addr  = (plane ? DEPTH_BASE : COLOR_BASE)
                   + ADDR_W'(32'(st == S_WCMD ? cur_tile : new_tile) * TILE_BYTES)
                   + ADDR_W'({idx, 2'b00});
  assign wr_valid  = st == S_WDAT;
  assign wr_data   = plane ? zram[idx] : cram[idx];
  assign wr_fire   = wr_valid && wr_ready;
  assign rd_fire   = st == S_RDAT && rd_valid;
  assign burst_end = &idx[BLB-1:0];
  assign plane_end = &idx;

  always_ff @(posedge clk) begin
    if (acc && zpass) begin
      cram[pidx] <= newc;
      if (zon) zram[pidx] <= pix_z;
    end
    if (rd_fire) begin
      if (plane) zram[idx] <= rd_data;
      else       cram[idx] <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      resident <= 1'b0; dirty <= 1'b0; zon <= 1'b0; zload <= 1'b0; plane <= 1'b0;
      cur_tile <= '0; new_tile <= '0; idx <= '0;
      reload_count <= '0; rd_bytes <= '0; wr_bytes <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (miss) begin
            new_tile <= tgt;
            zload <= z_en;
            plane <= 1'b0;
            idx <= '0;
            reload_count <= reload_count + CNT_W'(1);
            st <= (resident && dirty) ? S_WCMD : S_RCMD;
          end else if (acc && zpass) begin
            dirty <= 1'b1;
          end
        end
        S_WCMD: if (cmd_ready) st <= S_WDAT;
        S_WDAT: if (wr_fire) begin
          idx <= idx + IW'(1);
          wr_bytes <= wr_bytes + CNT_W'(4);
          if (burst_end) begin
            if (!plane_end)          st <= S_WCMD;
            else if (!plane && zon)  begin plane <= 1'b1; st <= S_WCMD; end
            else                     begin plane <= 1'b0; st <= S_RCMD; end
          end
        end
        S_RCMD: if (cmd_ready) st <= S_RDAT;
        S_RDAT: if (rd_fire) begin
          idx <= idx + IW'(1);
          rd_bytes <= rd_bytes + CNT_W'(4);
          if (burst_end) begin
            if (!plane_end)           st <= S_RCMD;
            else if (!plane && zload) begin plane <= 1'b1; st <= S_RCMD; end
            else begin
              st <= S_IDLE;
              plane <= 1'b0;
              resident <= 1'b1;
              cur_tile <= new_tile;
              dirty <= 1'b0;
              zon <= zload;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_reload_step: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> reload_count == $past(reload_count) + CNT_W'(1));

  a_r8_split_counts: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> $stable(wr_bytes) && rd_bytes != $past(rd_bytes));

  a_r9_clean_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !dirty) |=> cmd_valid && !cmd_write);

  a_r10_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> !cmd_valid && !wr_valid);

  a_r3_no_depth_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !(cmd_write ? zon : zload)) |-> cmd_addr < DEPTH_BASE);
endmodule

// File: tb/tb_tile_store.sv
module tb_tile_store;
  localparam int SW = 32, SH = 16, TLW = 8, TLH = 4, MB = 64, DB = 4096;
  localparam int BL = 16, TBYTES = 128, NB = 2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic z_en = 0, blend_en = 0, pix_valid = 0, pix_ready;
  logic [4:0] pix_x = 0;
  logic [3:0] pix_y = 0;
  logic [31:0] pix_z = 0, pix_color = 0;
  logic cmd_valid, cmd_ready = 0, cmd_write;
  logic [31:0] cmd_addr;
  logic [4:0] cmd_beats;
  logic wr_valid, wr_ready = 0, rd_valid = 0;
  logic [31:0] wr_data, rd_data = 0;
  logic [31:0] reload_count, rd_bytes, wr_bytes;

  tile_store #(.SCREEN_W(SW), .SCREEN_H(SH), .TILE_W(TLW), .TILE_H(TLH),
               .MAX_BURST_BYTES(MB), .DEPTH_BASE(32'h1000)) dut (
    .clk(clk), .rst_n(rst_n), .z_en(z_en), .blend_en(blend_en),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y),
    .pix_z(pix_z), .pix_color(pix_color), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_beats(cmd_beats),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .reload_count(reload_count),
    .rd_bytes(rd_bytes), .wr_bytes(wr_bytes));

  typedef struct {int x; int y; logic [31:0] z; logic [31:0] c; bit ze; bit be;} px_t;
  px_t pq[$];
  int total = 0, bad = 0, cyc = 0;
  logic [31:0] mem [int];
  logic [31:0] tru [int];
  bit mres = 0, mdirty = 0, mzon = 0, swapping = 0;
  int mcur = 0, mreload = 0, mrb = 0, mwb = 0;
  int eq_a[$];
  bit eq_w[$];
  int w_left = 0, r_left = 0, w_addr = 0, r_addr = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] init_val(int a);
    return (a >= DB) ? 32'h8000_0000 + 32'(a) : (32'(a) * 32'h0001_9E37) ^ 32'h3C5A_0F96;
  endfunction
  function automatic logic [31:0] tget(int a);
    return tru.exists(a) ? tru[a] : init_val(a);
  endfunction
  function automatic logic [31:0] mget(int a);
    return mem.exists(a) ? mem[a] : init_val(a);
  endfunction
  function automatic int tile_of(int x, int y);
    return (y / TLH) * (SW / TLW) + x / TLW;
  endfunction
  function automatic int caddr(int x, int y);
    return tile_of(x, y) * TBYTES + ((y % TLH) * TLW + x % TLW) * 4;
  endfunction
  function automatic logic [31:0] blendf(logic [31:0] s, logic [31:0] d);
    logic [31:0] r;
    int a;
    a = int'(s[31:24]);
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = 8'((int'(s[8*b +: 8]) * a + int'(d[8*b +: 8]) * (256 - a)) >> 8);
    return r;
  endfunction

  task automatic push_px(int x, int y, logic [31:0] z, logic [31:0] c, bit ze, bit be);
    px_t p;
    p.x = x; p.y = y; p.z = z; p.c = c; p.ze = ze; p.be = be;
    pq.push_back(p);
  endtask

  task automatic wait_idle(int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (pq.size() == 0 && !swapping) break;
    end
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R6 reload_count", reload_count, 32'(mreload));
      chk("R8 rd_bytes", rd_bytes, 32'(mrb));
      chk("R8 wr_bytes", wr_bytes, 32'(mwb));
    end
    cmd_ready = (w_left == 0 && r_left == 0 && cyc % 3 != 1);
    wr_ready = (w_left > 0 && cyc % 4 != 2);
    rd_valid = (r_left > 0 && cyc % 5 != 3);
    rd_data = rd_valid ? mget(r_addr) : 32'h0;
    if (pq.size() > 0) begin
      pix_valid = 1; pix_x = 5'(pq[0].x); pix_y = 4'(pq[0].y);
      pix_z = pq[0].z; pix_color = pq[0].c; z_en = pq[0].ze; blend_en = pq[0].be;
    end else pix_valid = 0;
    #1;
    if (rst_n) begin
      if (pix_valid) begin
        bit hit;
        hit = mres && tile_of(pq[0].x, pq[0].y) == mcur;
        chk("R10 pix_ready", 32'(pix_ready), 32'(!swapping && hit));
        if (pix_ready) begin
          int ca, za;
          bit pass;
          ca = caddr(pq[0].x, pq[0].y); za = ca + DB;
          pass = !mzon || pq[0].z <= tget(za);
          if (pass) begin
            tru[ca] = pq[0].be ? blendf(pq[0].c, tget(ca)) : pq[0].c;
            if (mzon) tru[za] = pq[0].z;
            mdirty = 1;
          end
          void'(pq.pop_front());
        end else if (!swapping && !hit) begin
          int nt;
          bit zl;
          nt = tile_of(pq[0].x, pq[0].y); zl = pq[0].ze;
          mreload++; swapping = 1;
          if (mres && mdirty)
            for (int p = 0; p <= (mzon ? 1 : 0); p++)
              for (int b = 0; b < NB; b++) begin
                eq_a.push_back(p * DB + mcur * TBYTES + b * BL * 4); eq_w.push_back(1);
              end
          for (int p = 0; p <= (zl ? 1 : 0); p++)
            for (int b = 0; b < NB; b++) begin
              eq_a.push_back(p * DB + nt * TBYTES + b * BL * 4); eq_w.push_back(0);
            end
          mres = 1; mcur = nt; mdirty = 0; mzon = zl;
        end
      end
      if (cmd_valid && cmd_ready) begin
        if (eq_a.size() == 0) begin
          total++; bad++;
          $display("FAIL R9 unexpected command actual=%h expected=none", cmd_addr);
        end else begin
          chk("R1 R3 R7 R9 cmd_addr", cmd_addr, 32'(eq_a[0]));
          chk("R7 R9 cmd_write", 32'(cmd_write), 32'(eq_w[0]));
          chk("R7 cmd_beats", 32'(cmd_beats), 32'(BL));
          if (cmd_write) begin w_left = BL; w_addr = int'(cmd_addr); end
          else begin r_left = BL; r_addr = int'(cmd_addr); end
          void'(eq_a.pop_front()); void'(eq_w.pop_front());
        end
      end
      if (wr_valid && wr_ready) begin
        chk("R2 R4 R5 flush data", wr_data, tget(w_addr));
        mem[w_addr] = wr_data; w_addr += 4; w_left--; mwb += 4;
      end
      if (rd_valid) begin
        r_addr += 4; r_left--; mrb += 4;
        if (r_left == 0 && eq_a.size() == 0) swapping = 0;
      end
    end
  end

  initial begin
    #(10 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wb0;
    logic [31:0] seed;
    int rt;
    repeat (3) @(negedge clk);
    #2;
    chk("R11 pix_ready reset", 32'(pix_ready), 0);
    chk("R11 cmd_valid reset", 32'(cmd_valid), 0);
    chk("R11 wr_valid reset", 32'(wr_valid), 0);
    chk("R11 counters reset", reload_count | rd_bytes | wr_bytes, 0);
    @(negedge clk); rst_n = 1;

    // depth off, blend off on tile 0, then move to tile 1
    push_px(1, 1, 0, 32'h1122_3344, 0, 0);
    push_px(1, 1, 0, 32'hCAFE_BABE, 0, 0);
    push_px(7, 3, 32'hFFFF_FFFF, 32'h0102_0304, 0, 0);
    push_px(9, 0, 0, 32'h0000_0055, 0, 0);
    wait_idle(2000);
    chk("R2 overwrite", mget(caddr(1, 1)), 32'hCAFE_BABE);
    chk("R2 R3 write ignores depth", mget(caddr(7, 3)), 32'h0102_0304);
    chk("R3 depth untouched", mget(caddr(1, 1) + DB), init_val(caddr(1, 1) + DB));
    chk("R3 R9 read bytes color only", rd_bytes, 32'd256);
    chk("R6 first two loads", reload_count, 32'd2);

    // depth on: tile 2
    push_px(17, 1, 32'h10, 32'h0000_000A, 1, 0);
    push_px(17, 1, 32'h20, 32'h0000_000C, 1, 0);
    push_px(17, 1, 32'h10, 32'h0000_000B, 1, 0);
    push_px(18, 1, 32'hFFFF_FFFF, 32'h0000_00EE, 1, 0);
    push_px(20, 2, 0, 32'h80FF_0040, 1, 1);
    push_px(21, 2, 0, 32'h0012_3456, 1, 1);
    push_px(22, 2, 0, 32'hFF80_4020, 1, 1);
    push_px(25, 0, 0, 32'h0000_0077, 0, 0);
    wait_idle(2000);
    chk("R4 equal depth passes", mget(caddr(17, 1)), 32'h0000_000B);
    chk("R4 depth stored", mget(caddr(17, 1) + DB), 32'h10);
    chk("R4 failing pixel keeps color", mget(caddr(18, 1)), init_val(caddr(18, 1)));
    chk("R4 failing pixel keeps depth", mget(caddr(18, 1) + DB), init_val(caddr(18, 1) + DB));
    chk("R5 blend half", mget(caddr(20, 2)), blendf(32'h80FF_0040, init_val(caddr(20, 2))));
    chk("R5 blend zero alpha", mget(caddr(21, 2)), init_val(caddr(21, 2)));
    chk("R5 blend full alpha", mget(caddr(22, 2)), blendf(32'hFF80_4020, init_val(caddr(22, 2))));

    // clean tile 4: only failing pixels, then leave it
    push_px(0, 4, 32'hFFFF_FFFF, 32'h1, 1, 0);
    wait_idle(2000);
    wb0 = int'(wr_bytes);
    push_px(9, 4, 0, 32'h2, 0, 0);
    wait_idle(2000);
    chk("R9 clean tile not flushed", wr_bytes, 32'(wb0));

    // mixed traffic
    seed = 32'h1357_9BDF; rt = 5;
    for (int i = 0; i < 200; i++) begin
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      if (seed[2:0] == 0) rt = int'(seed[11:8]);
      push_px((rt % 4) * TLW + int'(seed[14:12]), (rt / 4) * TLH + int'(seed[16:15]),
              32'h8000_0800 + 32'(seed[28:17] % 12'hC00) * 2, {seed[31:24], seed[23:0] ^ 24'hA5A5A5},
              seed[29], seed[30]);
    end
    wait_idle(60000);
    push_px(((mcur + 1) % 4) * TLW, (((mcur + 1) % 16) / 4) * TLH, 32'hFFFF_FFFF, 0, 1, 0);
    wait_idle(2000);
    for (int a = 0; a < 16 * TBYTES; a += 4) begin
      if (a / TBYTES != mcur) begin
        chk("R2 R4 R5 color image", mget(a), tget(a));
        chk("R3 R4 depth image", mget(a + DB), tget(a + DB));
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule